// File: doc/BRIEF.md
# Linked-List Scatter-Gather DMA Engine

This block copies data between memory regions over a simple single-master request/acknowledge memory port. It holds eight independent one-way channels. Each channel has a source address, a destination address, a next-descriptor pointer and a control word. The control word carries the element count, element width, byte order, per-side address stepping, burst length and enable. A fixed-priority arbiter decides which ready channel owns the engine. The lowest channel index wins, and a winner keeps the port for a whole burst.

Every element is read from its byte lanes at the source, optionally byte-reversed, and written into the matching lanes at the destination with byte enables. When a channel's count is used up, it follows its next pointer. It loads a four-word descriptor from memory and carries on with no software help. When the next pointer is null, the channel stops and raises a terminal-count flag. An error response aborts only the channel that was active.

Software programs a channel by writing the addresses and then the control word with the enable bit set. It can read every field back.

Top module: `dma_ll_engine`

## Requirements
- R1: When several channels are enabled at an arbitration point, the lowest-numbered one is served first.
- R2: A granted channel moves ctrl[23:21]+1 elements before the engine re-arbitrates, unless its count runs out first.
- R3: ctrl[17:16] selects the element width: 0 = 8 bit, 1 = 16 bit, 2 = 32 bit. The element is taken from the source word at byte lane src[1:0] and written at byte lane dst[1:0]. The byte enables cover only the element's bytes.
- R4: ctrl[18]=1 reverses the byte order inside each 16- or 32-bit element. 8-bit elements are unchanged.
- R5: ctrl[19] enables source stepping and ctrl[20] enables destination stepping. The step is 1, 2 or 4 bytes, equal to the element width. A side without stepping keeps its address fixed.
- R6: When the count (ctrl[15:0]) reaches zero and the next pointer is non-zero, the channel reads four words at next+0, +4, +8 and +12. These are loaded as source, destination, next and control. The enable bit of the loaded control word is ignored, and the channel continues.
- R7: When the count reaches zero with a null next pointer, the channel clears its enable (ctrl[24]) and sets its tc_flag bit. irq stays high while any tc_flag bit is set. Writing a channel's control word clears that channel's flags.
- R8: An error response aborts the active channel. It clears the channel's enable, sets its err_flag bit and leaves its count unchanged. Other channels still run.
- R9: reg_addr = {channel, field}, where field 0 = source, 1 = destination, 2 = next and 3 = control. reg_rdata returns the selected field, with live addresses and count.
- R10: A memory request keeps mem_req, mem_we and mem_addr stable until mem_ack, with one request outstanding at a time.
- R11: After reset no request is issued, all flags are clear and all channels are disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | {channel[2:0], field[1:0]} |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Selected field, combinational |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_wdata | output | 32 | Write data, lane-placed |
| mem_be | output | 4 | Byte enables for writes |
| mem_ack | input | 1 | Response for the pending request |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_err | input | 1 | Error response, valid with mem_ack |
| tc_flag | output | 8 | Per-channel terminal-count flags |
| err_flag | output | 8 | Per-channel error flags |
| irq | output | 1 | OR of tc_flag |

## Verification
A register write takes effect at the next clock edge. The channel is granted one cycle after that. Each element then costs one read and one write handshake, each finishing one cycle after its acknowledge. tc_flag and err_flag rise at the edge that closes the last element, the null-pointer check or the failing response. The bench therefore never samples at a fixed delay. It polls the flag it expects at falling edges, with a cycle limit, and only then compares memory contents, the log of write addresses, readback fields and irq. The priority test stalls the memory model's acknowledges while it enables three channels. This makes the arbitration order fixed rather than dependent on timing.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [2:0] {S_IDLE, S_RD, S_WR, S_END, S_DESC} dma_st_e;

  typedef struct packed {
    logic        en;
    logic [2:0]  burst;
    logic        dinc;
    logic        sinc;
    logic        big;
    logic [1:0]  wid;
    logic [15:0] cnt;
    logic [31:0] nxt;
    logic [31:0] dst;
    logic [31:0] src;
  } chan_t;

  function automatic logic [2:0] step_bytes(input logic [1:0] w);
    return (w == 2'd0) ? 3'd1 : (w == 2'd1) ? 3'd2 : 3'd4;
  endfunction

  function automatic logic [31:0] lane_get(input logic [31:0] word, input logic [1:0] off,
                                           input logic [1:0] w, input logic big);
    logic [31:0] sh;
    sh = word >> {off, 3'b000};
    case (w)
      2'd0:    return {24'd0, sh[7:0]};
      2'd1:    return big ? {16'd0, sh[7:0], sh[15:8]} : {16'd0, sh[15:0]};
      default: return big ? {sh[7:0], sh[15:8], sh[23:16], sh[31:24]} : sh;
    endcase
  endfunction

  function automatic logic [31:0] lane_put(input logic [31:0] e, input logic [1:0] off);
    return e << {off, 3'b000};
  endfunction

  function automatic logic [3:0] be_mask(input logic [1:0] w, input logic [1:0] off);
    logic [3:0] m;
    m = (w == 2'd0) ? 4'b0001 : (w == 2'd1) ? 4'b0011 : 4'b1111;
    return m << off;
  endfunction

  function automatic logic [31:0] pack_ctrl(input chan_t c);
    return {7'd0, c.en, c.burst, c.dinc, c.sinc, c.big, c.wid, c.cnt};
  endfunction

  function automatic chan_t apply_ctrl(input chan_t c, input logic [31:0] w);
    chan_t r;
    r = c;
    r.cnt = w[15:0];   r.wid = w[17:16]; r.big = w[18];
    r.sinc = w[19];    r.dinc = w[20];   r.burst = w[23:21]; r.en = w[24];
    return r;
  endfunction
endpackage

// File: rtl/dma_prio_arb.sv
module dma_prio_arb #(
  parameter int N = 8,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    gnt = '0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        gnt = '0;
        gnt[i] = 1'b1;
        idx = IW'(i);
      end
    end
    any = |req;
  end

  always_comb begin
    if (any) begin
      // R1
      arb_onehot_chk: assert ($onehot0(gnt) && (gnt & req) == gnt && gnt != '0);
      // R1
      arb_lowest_chk: assert ((req & (gnt - 1'b1)) == '0);
    end
  end
endmodule

// File: rtl/dma_chan_bank.sv
module dma_chan_bank
  import dma_pkg::*;
#(
  parameter int NCH = 8,
  localparam int CHW = $clog2(NCH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [CHW-1:0]     reg_ch,
  input  logic [1:0]         reg_fld,
  input  logic [31:0]        reg_wdata,
  input  logic               upd_v,
  input  logic [CHW-1:0]     upd_ch,
  input  chan_t              upd_chan,
  input  logic               ev_tc,
  input  logic               ev_err,
  output chan_t [NCH-1:0]    chans_o,
  output logic [NCH-1:0]     tc_o,
  output logic [NCH-1:0]     err_o
);
  for (genvar i = 0; i < NCH; i++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chans_o[i] <= '0;
        tc_o[i]    <= 1'b0;
        err_o[i]   <= 1'b0;
      end else begin
        if (upd_v && upd_ch == CHW'(i)) chans_o[i] <= upd_chan;
        if (ev_tc && upd_ch == CHW'(i)) tc_o[i] <= 1'b1;
        if (ev_err && upd_ch == CHW'(i)) err_o[i] <= 1'b1;
        if (reg_we && reg_ch == CHW'(i)) begin
          case (reg_fld)
            2'd0: chans_o[i].src <= reg_wdata;
            2'd1: chans_o[i].dst <= reg_wdata;
            2'd2: chans_o[i].nxt <= reg_wdata;
            default: begin
              chans_o[i] <= apply_ctrl(chans_o[i], reg_wdata);
              tc_o[i]    <= 1'b0;
              err_o[i]   <= 1'b0;
            end
          endcase
        end
      end
    end

    // R7
    tc_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tc_o[i]) |-> !chans_o[i].en);
    // R8
    err_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_o[i]) |-> !chans_o[i].en);
  end
endmodule

// File: rtl/dma_ll_engine.sv
module dma_ll_engine
  import dma_pkg::*;
#(
  parameter int NCH = 8,
  localparam int CHW = $clog2(NCH),
  localparam int RAW = CHW + 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_we,
  input  logic [RAW-1:0] reg_addr,
  input  logic [31:0]    reg_wdata,
  output logic [31:0]    reg_rdata,
  output logic           mem_req,
  output logic           mem_we,
  output logic [31:0]    mem_addr,
  output logic [31:0]    mem_wdata,
  output logic [3:0]     mem_be,
  input  logic           mem_ack,
  input  logic [31:0]    mem_rdata,
  input  logic           mem_err,
  output logic [NCH-1:0] tc_flag,
  output logic [NCH-1:0] err_flag,
  output logic           irq
);
  chan_t [NCH-1:0] chans;
  chan_t           cur, cur_n, upd_chan;
  dma_st_e         st, st_n;
  logic [CHW-1:0]  ch, ch_n, gidx;
  logic [2:0]      beats, beats_n;
  logic [1:0]      didx, didx_n;
  logic [31:0]     hold, hold_n, dbase, dbase_n, step;
  logic [NCH-1:0]  ready, gnt;
  logic            any, upd_v, ev_tc, ev_err;
  logic            abort_ev, elem_done_ev, burst_end_ev;

  for (genvar i = 0; i < NCH; i++) begin : g_rdy
    assign ready[i] = chans[i].en;
  end

  dma_prio_arb #(.N(NCH)) u_arb (.req(ready), .gnt(gnt), .idx(gidx), .any(any));

  dma_chan_bank #(.NCH(NCH)) u_bank (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_ch(reg_addr[RAW-1:2]),
    .reg_fld(reg_addr[1:0]), .reg_wdata(reg_wdata), .upd_v(upd_v), .upd_ch(ch),
    .upd_chan(upd_chan), .ev_tc(ev_tc), .ev_err(ev_err), .chans_o(chans),
    .tc_o(tc_flag), .err_o(err_flag));

  always_comb begin
    case (reg_addr[1:0])
      2'd0:    reg_rdata = chans[reg_addr[RAW-1:2]].src;
      2'd1:    reg_rdata = chans[reg_addr[RAW-1:2]].dst;
      2'd2:    reg_rdata = chans[reg_addr[RAW-1:2]].nxt;
      default: reg_rdata = pack_ctrl(chans[reg_addr[RAW-1:2]]);
    endcase
  end

  assign irq      = |tc_flag;
  assign step     = {29'd0, step_bytes(cur.wid)};
  assign abort_ev = mem_req && mem_ack && mem_err;

  always_comb begin
    st_n = st; cur_n = cur; ch_n = ch; beats_n = beats; hold_n = hold;
    didx_n = didx; dbase_n = dbase;
    upd_v = 1'b0; ev_tc = 1'b0; ev_err = 1'b0;
    elem_done_ev = 1'b0; burst_end_ev = 1'b0;
    mem_req = 1'b0; mem_we = 1'b0; mem_addr = '0; mem_wdata = '0; mem_be = '0;
    case (st)
      S_IDLE: if (any) begin
        cur_n = chans[gidx]; ch_n = gidx; beats_n = '0;
        st_n = (chans[gidx].cnt == 16'd0) ? S_END : S_RD;
      end
      S_RD: begin
        mem_req = 1'b1;
        mem_addr = {cur.src[31:2], 2'b00};
        if (mem_ack && !mem_err) begin
          hold_n = mem_rdata;
          st_n = S_WR;
        end
      end
      S_WR: begin
        mem_req = 1'b1; mem_we = 1'b1;
        mem_addr = {cur.dst[31:2], 2'b00};
        mem_wdata = lane_put(lane_get(hold, cur.src[1:0], cur.wid, cur.big), cur.dst[1:0]);
        mem_be = be_mask(cur.wid, cur.dst[1:0]);
        if (mem_ack && !mem_err) begin
          elem_done_ev = 1'b1;
          cur_n.src = cur.src + (cur.sinc ? step : 32'd0);
          cur_n.dst = cur.dst + (cur.dinc ? step : 32'd0);
          cur_n.cnt = cur.cnt - 16'd1;
          beats_n = beats + 3'd1;
          if (cur.cnt == 16'd1) st_n = S_END;
          else if (beats == cur.burst) begin
            burst_end_ev = 1'b1; upd_v = 1'b1; st_n = S_IDLE;
          end else st_n = S_RD;
        end
      end
      S_END: begin
        if (cur.nxt != 32'd0) begin
          dbase_n = cur.nxt; didx_n = '0; st_n = S_DESC;
        end else begin
          cur_n.en = 1'b0; upd_v = 1'b1; ev_tc = 1'b1; st_n = S_IDLE;
        end
      end
      default: begin
        mem_req = 1'b1;
        mem_addr = {dbase[31:2], 2'b00} + {28'd0, didx, 2'b00};
        if (mem_ack && !mem_err) begin
          case (didx)
            2'd0: cur_n.src = mem_rdata;
            2'd1: cur_n.dst = mem_rdata;
            2'd2: cur_n.nxt = mem_rdata;
            default: begin
              cur_n = apply_ctrl(cur, mem_rdata);
              cur_n.en = 1'b1;
            end
          endcase
          didx_n = didx + 2'd1;
          if (didx == 2'd3) begin
            upd_v = 1'b1; beats_n = '0; st_n = S_IDLE;
          end
        end
      end
    endcase
    if (abort_ev) begin
      cur_n = cur; cur_n.en = 1'b0;
      upd_v = 1'b1; ev_err = 1'b1; st_n = S_IDLE;
    end
    upd_chan = cur_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cur <= '0; ch <= '0; beats <= '0;
      hold <= '0; didx <= '0; dbase <= '0;
    end else begin
      st <= st_n; cur <= cur_n; ch <= ch_n; beats <= beats_n;
      hold <= hold_n; didx <= didx_n; dbase <= dbase_n;
    end
  end

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));
  // R3
  be_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> $countones(mem_be) == int'(step_bytes(cur.wid)));
  // R2
  chan_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE) |=> (st == S_IDLE || $stable(ch)));
  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> !mem_req);
endmodule

// File: tb/sim_dma_ll_engine.sv
module sim_dma_ll_engine;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [4:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [3:0] mem_be;
  logic mem_ack = 1'b0, mem_err = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic [7:0] tc_flag, err_flag;
  logic irq;

  logic [31:0] mem [256];
  logic [31:0] wlog [64];
  int nlog = 0;
  logic stall = 1'b0;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  dma_ll_engine u0 (.*);

  always @(posedge clk) begin
    mem_ack <= 1'b0;
    mem_err <= 1'b0;
    if (mem_req && !mem_ack && !stall) begin
      mem_ack <= 1'b1;
      if (mem_addr[31]) mem_err <= 1'b1;
      else if (mem_we) begin
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) mem[mem_addr[9:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
        wlog[nlog[5:0]] <= mem_addr;
        nlog <= nlog + 1;
      end else mem_rdata <= mem[mem_addr[9:2]];
    end
  end

  // {wid, big, src byte offset, dst byte offset, expected dst word}; source word A1B2C3D4
  localparam logic [38:0] VEC [6] = '{
    {2'd0, 1'b0, 2'd1, 2'd3, 32'hC300_0000},
    {2'd0, 1'b1, 2'd2, 2'd0, 32'h0000_00B2},
    {2'd1, 1'b0, 2'd2, 2'd0, 32'h0000_A1B2},
    {2'd1, 1'b1, 2'd0, 2'd2, 32'hD4C3_0000},
    {2'd2, 1'b0, 2'd0, 2'd0, 32'hA1B2_C3D4},
    {2'd2, 1'b1, 2'd0, 2'd0, 32'hD4C3_B2A1}
  };

  function automatic logic [31:0] mk_ctrl(int cnt, int wid, bit big, bit si, bit di, int bl, bit en);
    return {7'd0, en, bl[2:0], di, si, big, wid[1:0], cnt[15:0]};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int c, input int f, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = {c[2:0], f[1:0]}; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input int c, input int f, output logic [31:0] d);
    reg_addr = {c[2:0], f[1:0]};
    #1 d = reg_rdata;
  endtask

  task automatic wait_flag(input bit use_err, input int c);
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      if (use_err ? err_flag[c] : tc_flag[c]) break;
    end
  endtask

  task automatic prog(input int c, input logic [31:0] s, input logic [31:0] d,
                      input logic [31:0] n, input logic [31:0] ctl);
    wr(c, 0, s); wr(c, 1, d); wr(c, 2, n); wr(c, 3, ctl);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int base;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    mem[8'h40] = 32'hA1B2_C3D4;
    for (int i = 0; i < 4; i++) mem[8'h80 + i] = 32'hCAFE_0001 + i;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 mem_req", {31'd0, mem_req}, 32'd0);
    chk("R11 irq", {31'd0, irq}, 32'd0);
    chk("R11 flags", {16'd0, tc_flag, err_flag}, 32'd0);
    rd(0, 3, v); chk("R11 ctrl", v, 32'd0);

    // R3 R4 width / byte-order table
    for (int i = 0; i < 6; i++) begin
      logic [38:0] t;
      t = VEC[i];
      mem[8'h41] = '0;
      prog(0, 32'h100 + t[35:34], 32'h104 + t[33:32], 32'd0,
           mk_ctrl(1, t[38:37], t[36], 1, 1, 0, 1));
      wait_flag(0, 0);
      chk(t[36] ? "R4 byte order" : "R3 width/lanes", mem[8'h41], t[31:0]);
      wr(0, 3, 32'd0);
    end

    // R5 stepping on both sides, 16-bit elements
    prog(0, 32'h200, 32'h300, 32'd0, mk_ctrl(4, 1, 0, 1, 1, 7, 1));
    wait_flag(0, 0);
    chk("R5 inc word0", mem[8'hC0], 32'hCAFE_0001);
    chk("R5 inc word1", mem[8'hC1], 32'hCAFE_0002);
    wr(0, 3, 32'd0);
    // R5 fixed destination
    prog(0, 32'h200, 32'h310, 32'd0, mk_ctrl(3, 2, 0, 1, 0, 7, 1));
    wait_flag(0, 0);
    chk("R5 fixed dst last", mem[8'hC4], 32'hCAFE_0003);
    chk("R5 fixed dst next untouched", mem[8'hC5], 32'd0);
    wr(0, 3, 32'd0);

    // R6 descriptor chain
    mem[8'hE0] = 32'h204; mem[8'hE1] = 32'h324; mem[8'hE2] = 32'd0;
    mem[8'hE3] = mk_ctrl(2, 2, 0, 1, 1, 0, 0);
    prog(4, 32'h200, 32'h320, 32'h380, mk_ctrl(1, 2, 0, 1, 1, 0, 1));
    wait_flag(0, 4);
    chk("R6 chain first", mem[8'hC8], 32'hCAFE_0001);
    chk("R6 chain second", mem[8'hC9], 32'hCAFE_0002);
    chk("R6 chain third", mem[8'hCA], 32'hCAFE_0003);
    rd(4, 0, v); chk("R9 live src", v, 32'h20C);
    rd(4, 3, v); chk("R7 enable cleared", v, mk_ctrl(0, 2, 0, 1, 1, 0, 0));
    chk("R7 irq high", {31'd0, irq}, 32'd1);
    wr(4, 3, 32'd0);
    chk("R7 irq cleared", {31'd0, irq}, 32'd0);

    // R1 R2 priority and burst hold
    base = nlog;
    @(negedge clk); stall = 1'b1;
    prog(6, 32'h200, 32'h340, 32'd0, mk_ctrl(4, 2, 0, 1, 1, 1, 1));
    prog(3, 32'h200, 32'h360, 32'd0, mk_ctrl(1, 2, 0, 0, 0, 0, 1));
    prog(1, 32'h200, 32'h370, 32'd0, mk_ctrl(1, 2, 0, 0, 0, 0, 1));
    @(negedge clk); stall = 1'b0;
    wait_flag(0, 6);
    chk("R2 burst beat0", wlog[(base + 0) % 64], 32'h340);
    chk("R2 burst beat1", wlog[(base + 1) % 64], 32'h344);
    chk("R1 lowest first", wlog[(base + 2) % 64], 32'h370);
    chk("R1 next lowest", wlog[(base + 3) % 64], 32'h360);
    chk("R2 resume beat0", wlog[(base + 4) % 64], 32'h348);
    chk("R2 resume beat1", wlog[(base + 5) % 64], 32'h34C);
    wr(6, 3, 32'd0); wr(3, 3, 32'd0); wr(1, 3, 32'd0);

    // R8 error abort, other channel unaffected
    prog(2, 32'h8000_0000, 32'h380, 32'd0, mk_ctrl(2, 2, 0, 1, 1, 0, 1));
    wait_flag(1, 2);
    chk("R8 err flag", {24'd0, err_flag}, 32'h04);
    chk("R8 no tc", {24'd0, tc_flag}, 32'h00);
    rd(2, 3, v); chk("R8 disabled, count kept", v, mk_ctrl(2, 2, 0, 1, 1, 0, 0));
    mem[8'h41] = '0;
    prog(0, 32'h100, 32'h104, 32'd0, mk_ctrl(1, 2, 0, 1, 1, 0, 1));
    wait_flag(0, 0);
    chk("R8 other channel runs", mem[8'h41], 32'hA1B2_C3D4);
    wr(2, 3, 32'd0);
    chk("R7 ctrl write clears err", {24'd0, err_flag}, 32'h00);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule